// File: doc/BRIEF.md
# Standard Data Frame Transmit Serializer

This block shifts out one standard-format (11-bit identifier) data frame, one bit per bit strobe, onto a transmit line. A one-cycle start request captures the identifier, the length code and up to eight payload bytes. The block then produces the whole frame: the header, the payload, a CRC-15 that it computes itself while the header and payload go out, the delimiters, the acknowledge slot, the end-of-frame run and the interframe space. Bit timing, bit stuffing and receive decoding belong to neighbouring blocks. The bit strobe comes from the bit-timing logic. The bus read-back comes from the line receiver.

The acknowledge slot is driven recessive. The bus level read back when that slot closes decides how the frame ends. A dominant read-back gives a success pulse and the block returns to idle. A recessive read-back gives an acknowledge-error pulse, and the block sends the same frame again from its first bit with no new request. A done pulse marks the end of every attempt.

Top module: `can_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_bit_o` is 1 (recessive) and `busy_o` is 0. Bit strobes given while idle change neither. An asynchronous reset in the middle of a frame returns the block to this idle state.
- R2: A `start_i` pulse while idle captures `id_i`, `dlc_i` and `data_i`, raises `busy_o` and drives the dominant start bit (0) in the next cycle. Changes to those inputs, and further `start_i` pulses, have no effect on a frame in progress.
- R3: The frame bit positions, counted from 0 at the start bit, are fixed. Position 0 is the start bit (0). Positions 1 to 11 carry the identifier, MSB first. Positions 12 to 14 carry three dominant control bits (0). Positions 15 to 18 carry the length code, MSB first. The data follows from position 19: byte 0 is `data_i[63:56]`, and every byte goes MSB first.
- R4: The payload holds n = min(`dlc_i`, 8) bytes. The frame is 44 + 8n bits from the start bit through end-of-frame, for example 68 bits for n = 3. Three interframe bits follow, so one attempt takes 47 + 8n strobes.
- R5: The 15 bits after the data carry a CRC-15 with polynomial 0x4599 and initial value 0. It is computed MSB first over the start bit through the last data bit, and it is sent MSB first.
- R6: The CRC delimiter, the acknowledge slot, the acknowledge delimiter, the seven end-of-frame bits and the three interframe bits are all recessive (1).
- R7: `rx_bit_i` is sampled at the strobe that ends the acknowledge slot. If it is 0, `tx_ok_o` pulses at the end of the attempt. If it is 1, `ack_err_o` pulses instead. The two never pulse together.
- R8: `done_o` pulses for exactly one cycle, in the cycle after the final interframe strobe. It pulses together with `tx_ok_o` or `ack_err_o`, and at no other time.
- R9: After an acknowledge error, `busy_o` stays 1 and the identical frame, CRC included, is sent again from the start bit without a new `start_i`.
- R10: While a frame is in progress, `tx_bit_o` changes only in the cycle after a bit strobe. Between strobes it holds its value for any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to send a frame |
| id_i | input | 11 | Frame identifier |
| dlc_i | input | 4 | Data length code |
| data_i | input | 64 | Payload, byte 0 in bits 63:56 |
| bit_en_i | input | 1 | Bit strobe: one frame bit per strobe |
| rx_bit_i | input | 1 | Bus level read back |
| tx_bit_o | output | 1 | Transmit bit, 1 = recessive |
| busy_o | output | 1 | Frame attempt in progress |
| tx_ok_o | output | 1 | Pulse: frame acknowledged |
| ack_err_o | output | 1 | Pulse: acknowledge slot read recessive |
| done_o | output | 1 | Pulse: attempt finished |

## Verification
The bench targets the length boundaries: an empty payload, a full eight-byte payload, and a length code above 8. A design that used the raw code for the byte count would send too many bytes, so the CRC and the done pulse would fall late. The CRC is checked bit by bit against an independent model. An off-by-one in the CRC's scope, for example including the length field twice or leaving out the start bit, changes every CRC bit that follows. An unacknowledged attempt is checked for its error pulse and for a retransmission that matches bit for bit. A design that kept the old CRC state or that dropped to idle would diverge at once. Corrupting the inputs in mid-frame, holding the output between strobes, and resetting in mid-frame all expose a design that latches too late or advances without a strobe.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;
  localparam int ID_W      = 11;
  localparam int DLC_W     = 4;
  localparam int MAX_BYTES = 8;
  localparam int DATA_W    = 8 * MAX_BYTES;
  localparam int NB_W      = $clog2(MAX_BYTES + 1);
  localparam int CRC_W     = 15;
  localparam logic [CRC_W-1:0] CRC_POLY = 15'h4599;
  localparam int CTL_BITS  = 3;  // RTR, IDE, r0
  localparam int EOF_LEN   = 7;
  localparam int IFS_LEN   = 3;
  localparam int HDR_LEN   = 1 + ID_W + CTL_BITS + DLC_W;
  localparam int TAIL_LEN  = CRC_W + 3 + EOF_LEN + IFS_LEN;
  localparam int MAX_LEN   = HDR_LEN + DATA_W + TAIL_LEN;
  localparam int POS_W     = $clog2(MAX_LEN);

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [DLC_W-1:0]  dlc;
    logic [DATA_W-1:0] data;
    logic [NB_W-1:0]   nbytes;
  } frame_t;
endpackage

// File: rtl/can_tx_crc15.sv
module can_tx_crc15
  import can_tx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q;
  logic             fb;

  assign fb = bit_i ^ crc_q[CRC_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '0;
    else if (clear_i) crc_q <= '0;
    else if (shift_i) crc_q <= {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/can_tx_bitsel.sv
module can_tx_bitsel
  import can_tx_pkg::*;
(
  input  logic [POS_W-1:0] pos_i,
  input  frame_t           frame_i,
  input  logic [CRC_W-1:0] crc_i,
  output logic             bit_o,
  output logic             crc_scope_o,
  output logic             is_ack_o,
  output logic             is_last_o
);
  localparam logic [POS_W-1:0] P_ID   = POS_W'(1);
  localparam logic [POS_W-1:0] P_CTL  = POS_W'(1 + ID_W);
  localparam logic [POS_W-1:0] P_DLC  = POS_W'(1 + ID_W + CTL_BITS);
  localparam logic [POS_W-1:0] P_DATA = POS_W'(HDR_LEN);
  localparam logic [POS_W-1:0] L_CRC  = POS_W'(CRC_W);
  localparam logic [POS_W-1:0] L_ACK  = POS_W'(CRC_W + 1);
  localparam logic [POS_W-1:0] L_LAST = POS_W'(TAIL_LEN - 1);

  logic [POS_W-1:0]  data_end, crc_end;
  logic [ID_W-1:0]   id_sh;
  logic [DLC_W-1:0]  dlc_sh;
  logic [DATA_W-1:0] data_sh;
  logic [CRC_W-1:0]  crc_sh;

  assign data_end = P_DATA + (POS_W'(frame_i.nbytes) << 3);
  assign crc_end  = data_end + L_CRC;
  assign id_sh    = frame_i.id   << (pos_i - P_ID);
  assign dlc_sh   = frame_i.dlc  << (pos_i - P_DLC);
  assign data_sh  = frame_i.data << (pos_i - P_DATA);
  assign crc_sh   = crc_i        << (pos_i - data_end);

  always_comb begin
    bit_o = 1'b1;
    if (pos_i == '0)           bit_o = 1'b0;
    else if (pos_i < P_CTL)    bit_o = id_sh[ID_W-1];
    else if (pos_i < P_DLC)    bit_o = 1'b0;
    else if (pos_i < P_DATA)   bit_o = dlc_sh[DLC_W-1];
    else if (pos_i < data_end) bit_o = data_sh[DATA_W-1];
    else if (pos_i < crc_end)  bit_o = crc_sh[CRC_W-1];
  end

  assign crc_scope_o = pos_i < data_end;
  assign is_ack_o    = pos_i == data_end + L_ACK;
  assign is_last_o   = pos_i == data_end + L_LAST;
endmodule

// File: rtl/can_frame_tx.sv
module can_frame_tx
  import can_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [DLC_W-1:0]  dlc_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              bit_en_i,
  input  logic              rx_bit_i,
  output logic              tx_bit_o,
  output logic              busy_o,
  output logic              tx_ok_o,
  output logic              ack_err_o,
  output logic              done_o
);
  frame_t           frame_q;
  logic [POS_W-1:0] pos_q;
  logic             busy_q, acked_q, ok_q, err_q, done_q;
  logic             sel_bit, crc_scope, is_ack, is_last;
  logic [CRC_W-1:0] crc;
  logic             step;

  assign step = busy_q && bit_en_i;

  can_tx_bitsel u_sel (
    .pos_i      (pos_q),
    .frame_i    (frame_q),
    .crc_i      (crc),
    .bit_o      (sel_bit),
    .crc_scope_o(crc_scope),
    .is_ack_o   (is_ack),
    .is_last_o  (is_last)
  );

  // CRC restarts for every attempt, including retransmissions
  can_tx_crc15 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(!busy_q || (step && is_last)),
    .shift_i(step && crc_scope),
    .bit_i  (sel_bit),
    .crc_o  (crc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      pos_q   <= '0;
      busy_q  <= 1'b0;
      acked_q <= 1'b0;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      ok_q   <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          frame_q.id     <= id_i;
          frame_q.dlc    <= dlc_i;
          frame_q.data   <= data_i;
          frame_q.nbytes <= (dlc_i > DLC_W'(MAX_BYTES)) ? NB_W'(MAX_BYTES) : NB_W'(dlc_i);
          pos_q          <= '0;
          busy_q         <= 1'b1;
        end
      end else if (bit_en_i) begin
        if (is_ack) acked_q <= !rx_bit_i;
        if (is_last) begin
          pos_q  <= '0;
          done_q <= 1'b1;
          if (acked_q) begin
            ok_q   <= 1'b1;
            busy_q <= 1'b0;
          end else begin
            err_q  <= 1'b1;
          end
        end else begin
          pos_q <= pos_q + POS_W'(1);
        end
      end
    end
  end

  assign tx_bit_o  = busy_q ? sel_bit : 1'b1;
  assign busy_o    = busy_q;
  assign tx_ok_o   = ok_q;
  assign ack_err_o = err_q;
  assign done_o    = done_q;

  AST_IDLE_RECESSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_bit_o); // R1
  AST_OK_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_ok_o && ack_err_o)); // R7
  AST_DONE_WITH_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (tx_ok_o || ack_err_o)); // R8
  AST_OK_GOES_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ok_o |-> !busy_o); // R8
  AST_RETRY_STAYS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_err_o |-> busy_o); // R9
  AST_HOLD_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !bit_en_i) |=> $stable(tx_bit_o)); // R10
endmodule

// File: tb/tb_can_frame_tx.sv
`timescale 1ns/1ps
module tb_can_frame_tx;
  typedef struct packed {
    logic [10:0] id;
    logic [3:0]  dlc;
    logic [63:0] data;
    logic        ack;
    logic        disturb;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{11'h123, 4'd3,  64'hA55AC30000000000, 1'b1, 1'b0},
    '{11'h000, 4'd0,  64'h0,                1'b1, 1'b0},
    '{11'h7FF, 4'd8,  64'hDEADBEEF01234567, 1'b1, 1'b0},
    '{11'h155, 4'd15, 64'h0F1E2D3C4B5A6978, 1'b1, 1'b0},
    '{11'h2AA, 4'd1,  64'hFF00000000000000, 1'b0, 1'b0},
    '{11'h001, 4'd5,  64'h1122334455667788, 1'b1, 1'b1}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, bit_en_i = 1'b0, rx_bit_i = 1'b1;
  logic [10:0] id_i = '0;
  logic [3:0]  dlc_i = '0;
  logic [63:0] data_i = '0;
  logic tx_bit_o, busy_o, tx_ok_o, ack_err_o, done_o;

  int n_chk = 0, n_fail = 0;
  logic exp_bits [0:127];
  int exp_len, exp_ack, exp_dend;

  always #2.5 clk = ~clk;

  can_frame_tx dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .id_i(id_i), .dlc_i(dlc_i),
    .data_i(data_i), .bit_en_i(bit_en_i), .rx_bit_i(rx_bit_i), .tx_bit_o(tx_bit_o),
    .busy_o(busy_o), .tx_ok_o(tx_ok_o), .ack_err_o(ack_err_o), .done_o(done_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic build(input logic [10:0] id, input logic [3:0] dlc, input logic [63:0] data);
    int n, k;
    logic [14:0] c;
    n = (dlc > 8) ? 8 : dlc;
    k = 0;
    exp_bits[k++] = 1'b0;
    for (int i = 10; i >= 0; i--) exp_bits[k++] = id[i];
    for (int i = 0; i < 3; i++) exp_bits[k++] = 1'b0;
    for (int i = 3; i >= 0; i--) exp_bits[k++] = dlc[i];
    for (int i = 0; i < 8 * n; i++) exp_bits[k++] = data[63 - i];
    exp_dend = k;
    c = '0;
    for (int i = 0; i < k; i++) begin
      logic fb;
      fb = exp_bits[i] ^ c[14];
      c = {c[13:0], 1'b0};
      if (fb) c = c ^ 15'h4599;
    end
    for (int i = 14; i >= 0; i--) exp_bits[k++] = c[i];
    exp_bits[k++] = 1'b1;
    exp_ack = k;
    for (int i = 0; i < 12; i++) exp_bits[k++] = 1'b1;
    exp_len = k;
  endtask

  task automatic run_frame(input vec_t v, input logic ack, input bit do_start);
    string tag;
    build(v.id, v.dlc, v.data);
    check("R4 length", 64'(exp_len), 64'(47 + 8 * ((v.dlc > 8) ? 8 : v.dlc)));
    if (do_start) begin
      @(negedge clk);
      id_i = v.id; dlc_i = v.dlc; data_i = v.data; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check("R2 busy after start", 64'(busy_o), 64'd1);
      if (v.disturb) begin
        id_i = ~v.id; dlc_i = 4'd2; data_i = ~v.data;
      end
    end
    for (int b = 0; b < exp_len; b++) begin
      tag = (b < exp_dend) ? "R3 header/data" : (b < exp_dend + 15) ? "R5 crc" : "R6 tail";
      check(tag, 64'(tx_bit_o), 64'(exp_bits[b]));
      check("R8 no early end", 64'({done_o, tx_ok_o, ack_err_o}), 64'd0);
      if (b == 5 && !v.disturb) begin
        repeat (10) @(negedge clk);
        check("R10 hold between strobes", 64'(tx_bit_o), 64'(exp_bits[b]));
      end
      if (v.disturb && b == 3) begin
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R2 start ignored while busy", 64'(tx_bit_o), 64'(exp_bits[b]));
      end
      rx_bit_i = (b == exp_ack) ? !ack : exp_bits[b];
      bit_en_i = 1'b1;
      @(negedge clk);
      bit_en_i = 1'b0;
      rx_bit_i = 1'b1;
      if (b < exp_len - 1) @(negedge clk);
    end
    check("R4 R8 done pulse", 64'(done_o), 64'd1);
    check("R7 tx_ok", 64'(tx_ok_o), 64'(ack));
    check("R7 ack_err", 64'(ack_err_o), 64'(!ack));
    @(negedge clk);
    check("R8 single-cycle pulses", 64'({done_o, tx_ok_o, ack_err_o}), 64'd0);
    check(ack ? "R1 idle busy" : "R9 retry busy", 64'(busy_o), 64'(!ack));
    check(ack ? "R1 idle recessive" : "R9 retry SOF", 64'(tx_bit_o), 64'(ack));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 reset tx_bit", 64'(tx_bit_o), 64'd1);
    check("R1 reset busy", 64'(busy_o), 64'd0);
    check("R1 reset pulses", 64'({done_o, tx_ok_o, ack_err_o}), 64'd0);

    // idle strobes with a dominant read-back
    rx_bit_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      bit_en_i = 1'b1; @(negedge clk); bit_en_i = 1'b0; @(negedge clk);
    end
    rx_bit_i = 1'b1;
    check("R1 idle strobes tx_bit", 64'(tx_bit_o), 64'd1);
    check("R1 idle strobes busy", 64'(busy_o), 64'd0);

    for (int v = 0; v < NV; v++) begin
      run_frame(VECS[v], VECS[v].ack, 1'b1);
      if (!VECS[v].ack) run_frame(VECS[v], 1'b1, 1'b0); // R9 retransmission
    end

    // reset in mid-frame
    @(negedge clk);
    id_i = 11'h3C3; dlc_i = 4'd2; data_i = '0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      bit_en_i = 1'b1; @(negedge clk); bit_en_i = 1'b0; @(negedge clk);
    end
    rst_ni = 1'b0;
    @(negedge clk);
    check("R1 mid-frame reset busy", 64'(busy_o), 64'd0);
    check("R1 mid-frame reset tx_bit", 64'(tx_bit_o), 64'd1);
    rst_ni = 1'b1;
    @(negedge clk);
    run_frame(VECS[0], 1'b1, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule